// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel flash device. It decides when an embedded program or erase has finished by reading the device repeatedly. The host first writes the full command sequence. Once the last write cycle of that sequence has ended, the host pulses `start_i` with four values: a poll address inside the block under operation, the byte it expects to find there, a check mode, and a limit on the number of poll reads. The poller then issues fixed-length read strobes over a simple parallel read port. It decides between reads whether the operation has completed, and finishes with one extra confirming read. The byte from that confirming read is the only byte treated as valid.

The block supports two completion checks. In data-bit mode, the operation is complete when bit 7 of a read equals bit 7 of the expected byte (for an erase, the expected bit 7 is 1). In toggle mode, the operation is complete when two consecutive reads return the same value on bit 6. On the read where bit 7 first shows completion, the lower bits may still hold stale data. For this reason the confirming read is mandatory in both modes, and in data-bit mode its byte must equal the expected byte.

The controller is a state machine with six states: `P_IDLE`, `P_READ`, `P_COMPARE`, `P_CONFIRM`, `P_DONE` and `P_FAIL`. The transitions are:
- `P_IDLE` to `P_READ` on `start_i`.
- `P_READ` to `P_COMPARE` when a read strobe ends.
- `P_COMPARE` to `P_CONFIRM` when completion is seen.
- `P_COMPARE` to `P_FAIL` when the limit is reached without completion.
- `P_COMPARE` back to `P_READ` otherwise.
- `P_CONFIRM` to `P_DONE` or `P_FAIL` when the confirming strobe ends.
- `P_DONE` and `P_FAIL` both return to `P_IDLE` after one cycle.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_en_o`, `pass_o` and `result_o` are all 0, and no read strobe is issued until `start_i` is seen.
- R2: `start_i` is accepted only when the block is idle. On acceptance, `rd_en_o` and `busy_o` are high in the next cycle. A `start_i` pulse while busy changes neither the address, the mode nor the outcome of the running operation.
- R3: Each read holds `rd_en_o` high for exactly `ACCESS_CYC` cycles. The data is sampled on the last of those cycles, and `rd_en_o` then stays low for at least one cycle before the next read.
- R4: Every read of an operation, including the confirming read, presents the address latched at start.
- R5: With `mode_i`=0, a poll read completes the operation when its bit 7 equals bit 7 of the expected byte.
- R6: With `mode_i`=1, a poll read completes the operation when its bit 6 equals bit 6 of the previous poll read of the same operation. The first poll read never completes it.
- R7: After completion, exactly one confirming read follows, and `result_o` is that read's full byte, even if the completing read showed stale bits 6..0.
- R8: With `mode_i`=0, if the confirming byte differs from the expected byte, the outcome is fail (`pass_o`=0).
- R9: With `mode_i`=1, the expected byte has no effect, and a completed operation passes.
- R10: If `max(limit_i,1)` poll reads have been made without completion, the outcome is fail with no confirming read, and `result_o` is the last poll byte.
- R11: `done_o` is a one-cycle pulse, after which the block is idle. `pass_o` and `result_o` change together with `done_o` and hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin polling (honoured only when idle) |
| mode_i | input | 1 | 0: bit 7 data check, 1: bit 6 toggle check |
| addr_i | input | ADDR_W | Poll address inside the busy block |
| expect_i | input | DATA_W | Byte expected after completion |
| limit_i | input | LIMIT_W | Maximum number of poll reads |
| rd_en_o | output | 1 | Read strobe to the flash |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | DATA_W | Read data from the flash |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Outcome of the last operation |
| result_o | output | DATA_W | Byte of the confirming read (or last poll byte on timeout) |

## Verification
The bench responder returns the complement of bit 7 while busy, and on the completing read it returns true bit 7 with stale low bits. A poller that skipped the confirming read would therefore report a wrong byte or a false mismatch. In toggle mode the responder alternates bit 6 until completion. A design that treated the first read as complete, or compared against the expected byte, would finish one read early or fail a good operation. The limit cases cover an exact fit, an overrun, and a limit of zero; an off-by-one counter shows up as a wrong read count. A start pulse in mid-operation with a different address and mode checks that the running poll is not redirected.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic [2:0] {
        P_IDLE,
        P_READ,
        P_COMPARE,
        P_CONFIRM,
        P_DONE,
        P_FAIL
    } poll_state_e;

    typedef enum logic {
        MODE_DATA7   = 1'b0,
        MODE_TOGGLE6 = 1'b1
    } poll_mode_e;
endpackage

// File: rtl/poll_read_seq.sv
module poll_read_seq #(
    parameter int DATA_W     = 8,
    parameter int ACCESS_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              rd_en_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int CNT_W = $clog2(ACCESS_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ACCESS_CYC - 1);

    typedef enum logic [1:0] {SQ_IDLE, SQ_ACT, SQ_GAP} seq_state_e;

    seq_state_e       sq;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq     <= SQ_IDLE;
            cnt    <= '0;
            data_o <= '0;
        end else begin
            unique case (sq)
                SQ_IDLE: begin
                    if (go_i) begin
                        sq  <= SQ_ACT;
                        cnt <= '0;
                    end
                end
                SQ_ACT: begin
                    if (cnt == LAST) begin
                        data_o <= rd_data_i;
                        sq     <= SQ_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_GAP:  sq <= SQ_IDLE;
                default: sq <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_en_o = (sq == SQ_ACT);
        ack_o   = (sq == SQ_GAP);
    end

    // R3
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_en_o) |=> !rd_en_o);

    // R2
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (sq == SQ_IDLE));
endmodule

// File: rtl/poll_judge.sv
module poll_judge #(
    parameter int DATA_W = 8
) (
    input  poll_pkg::poll_mode_e mode_i,
    input  logic [DATA_W-1:0]    byte_i,
    input  logic                 exp_bit7_i,
    input  logic                 prev_bit6_i,
    input  logic                 have_prev_i,
    output logic                 complete_o
);
    localparam int B7 = 7;
    localparam int B6 = 6;

    always_comb begin
        unique case (mode_i)
            poll_pkg::MODE_DATA7:   complete_o = (byte_i[B7] == exp_bit7_i);
            poll_pkg::MODE_TOGGLE6: complete_o = have_prev_i && (byte_i[B6] == prev_bit6_i);
            default:                complete_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/poll_iter_cnt.sv
module poll_iter_cnt #(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               inc_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               reached_o
);
    localparam logic [LIMIT_W-1:0] SAT = '1;

    logic [LIMIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr_i) begin
            cnt <= '0;
        end else if (inc_i && cnt != SAT) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb reached_o = (cnt >= limit_i);
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int LIMIT_W    = 16,
    parameter int ACCESS_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               mode_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  expect_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               rd_en_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               pass_o,
    output logic [DATA_W-1:0]  result_o
);
    import poll_pkg::*;

    localparam int B6 = 6;
    localparam int B7 = 7;

    poll_state_e        state, state_n;
    poll_mode_e         mode_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  exp_q;
    logic [LIMIT_W-1:0] limit_q;
    logic               prev6_q, have_prev_q;
    logic               go, seq_ack, complete, reached;
    logic [DATA_W-1:0]  seq_data;
    logic               accept;

    poll_read_seq #(.DATA_W(DATA_W), .ACCESS_CYC(ACCESS_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .rd_data_i (rd_data_i),
        .rd_en_o   (rd_en_o),
        .ack_o     (seq_ack),
        .data_o    (seq_data)
    );

    poll_judge #(.DATA_W(DATA_W)) u_judge (
        .mode_i      (mode_q),
        .byte_i      (seq_data),
        .exp_bit7_i  (exp_q[B7]),
        .prev_bit6_i (prev6_q),
        .have_prev_i (have_prev_q),
        .complete_o  (complete)
    );

    poll_iter_cnt #(.LIMIT_W(LIMIT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept),
        .inc_i     (state == P_READ && seq_ack),
        .limit_i   (limit_q),
        .reached_o (reached)
    );

    // Next-state and read launch
    always_comb begin
        state_n = state;
        go      = 1'b0;
        accept  = 1'b0;
        unique case (state)
            P_IDLE: begin
                if (start_i) begin
                    state_n = P_READ;
                    go      = 1'b1;
                    accept  = 1'b1;
                end
            end
            P_READ: begin
                if (seq_ack) state_n = P_COMPARE;
            end
            P_COMPARE: begin
                if (complete) begin
                    state_n = P_CONFIRM;
                    go      = 1'b1;
                end else if (reached) begin
                    state_n = P_FAIL;
                end else begin
                    state_n = P_READ;
                    go      = 1'b1;
                end
            end
            P_CONFIRM: begin
                if (seq_ack) begin
                    if (mode_q == MODE_DATA7 && seq_data != exp_q) state_n = P_FAIL;
                    else                                          state_n = P_DONE;
                end
            end
            P_DONE:  state_n = P_IDLE;
            P_FAIL:  state_n = P_IDLE;
            default: state_n = P_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= P_IDLE;
        else        state <= state_n;
    end

    // Operation context and outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_DATA7;
            addr_q      <= '0;
            exp_q       <= '0;
            limit_q     <= '0;
            prev6_q     <= 1'b0;
            have_prev_q <= 1'b0;
            pass_o      <= 1'b0;
            result_o    <= '0;
        end else begin
            if (accept) begin
                mode_q      <= poll_mode_e'(mode_i);
                addr_q      <= addr_i;
                exp_q       <= expect_i;
                limit_q     <= limit_i;
                have_prev_q <= 1'b0;
            end
            if (state == P_COMPARE) begin
                prev6_q     <= seq_data[B6];
                have_prev_q <= 1'b1;
            end
            if (state != P_DONE && state != P_FAIL &&
                (state_n == P_DONE || state_n == P_FAIL)) begin
                pass_o   <= (state_n == P_DONE);
                result_o <= seq_data;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o    = (state != P_IDLE);
        done_o    = (state == P_DONE) || (state == P_FAIL);
        rd_addr_o = addr_q;
    end

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

    // R2
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(rd_addr_o) && $stable(mode_q)));

    // R8
    confirm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && pass_o && mode_q == MODE_DATA7) |-> (result_o == exp_q));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o) |-> !rd_en_o);
endmodule

// File: tb/flash_done_poller_bench.sv
module flash_done_poller_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ACCESS     = 3;
    localparam int NVEC       = 11;

    // {mode[48], busy_reads[47:40], final[39:32], stale[31:24], expect[23:16], limit[15:0]}
    localparam logic [48:0] VEC [NVEC] = '{
        {1'b0, 8'd3,  8'hA5, 8'h3C, 8'hA5, 16'd10},
        {1'b0, 8'd0,  8'h81, 8'h00, 8'h81, 16'd4},
        {1'b0, 8'd5,  8'hFF, 8'h12, 8'hFF, 16'd20},
        {1'b0, 8'd2,  8'hA4, 8'h55, 8'hA5, 16'd10},
        {1'b0, 8'd10, 8'hC3, 8'h2B, 8'hC3, 16'd4},
        {1'b1, 8'd4,  8'h40, 8'h11, 8'h40, 16'd20},
        {1'b1, 8'd0,  8'h00, 8'h99, 8'h00, 16'd4},
        {1'b1, 8'd30, 8'h6E, 8'hA0, 8'h6E, 16'd5},
        {1'b1, 8'd3,  8'h77, 8'h0F, 8'h00, 16'd10},
        {1'b0, 8'd2,  8'h5A, 8'h21, 8'h5A, 16'd0},
        {1'b0, 8'd3,  8'h96, 8'h44, 8'h96, 16'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  expect_i = '0;
    logic [15:0] limit_i = '0;
    logic        rd_en_o;
    logic [15:0] rd_addr_o;
    logic [7:0]  rd_data_i = '0;
    logic        busy_o, done_o, pass_o;
    logic [7:0]  result_o;

    int checks = 0;
    int failures = 0;

    // responder state
    logic        cfg_mode = 1'b0;
    int          cfg_n = 0;
    logic [7:0]  cfg_f = '0;
    logic [7:0]  cfg_s = '0;
    logic [15:0] cur_addr = '0;
    int          rd_k = 0;
    int          hi_len = 0;
    int          strobe_err = 0;
    int          addr_err = 0;
    logic        en_prev = 1'b0;

    flash_done_poller #(.ACCESS_CYC(ACCESS)) u_flash_done_poller (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mode_i    (mode_i),
        .addr_i    (addr_i),
        .expect_i  (expect_i),
        .limit_i   (limit_i),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o),
        .rd_data_i (rd_data_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .pass_o    (pass_o),
        .result_o  (result_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] val_at(int k);
        if (cfg_mode == 1'b0) begin
            if (k < cfg_n)       return {~cfg_f[7], cfg_s[6:0]};
            else if (k == cfg_n) return {cfg_f[7], cfg_s[6:0]};
            else                 return cfg_f;
        end else begin
            if (k < cfg_n) return {cfg_s[7], k[0], cfg_s[5:0]};
            else           return cfg_f;
        end
    endfunction

    always @(negedge clk) begin
        if (rd_en_o) begin
            if (!en_prev) begin
                rd_data_i = val_at(rd_k);
                rd_k++;
                hi_len = 0;
            end
            hi_len++;
            if (rd_addr_o !== cur_addr) addr_err++;
        end else if (en_prev) begin
            if (hi_len != ACCESS) strobe_err++;
        end
        en_prev = rd_en_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [48:0] v, input logic [15:0] a, input bit disturb);
        int   lim_eff, c, e_reads, n;
        bit   found, e_pass;
        logic [7:0] e_res;
        logic [7:0] old_res;
        logic       old_pass;
        cfg_mode = v[48];
        cfg_n    = int'(v[47:40]);
        cfg_f    = v[39:32];
        cfg_s    = v[31:24];
        cur_addr = a;
        @(negedge clk);
        rd_k = 0; strobe_err = 0; addr_err = 0;
        start_i  = 1'b1;
        mode_i   = v[48];
        addr_i   = a;
        expect_i = v[23:16];
        limit_i  = v[15:0];
        @(negedge clk);
        start_i = 1'b0;
        chk(rd_en_o === 1'b1 && busy_o === 1'b1, "R2 strobe after start", rd_en_o, 1);
        n = 0;
        while (!done_o && n < 5000) begin
            if (disturb && n == 4) begin
                start_i = 1'b1; addr_i = 16'hBEEF; mode_i = ~v[48]; expect_i = 8'h00;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        chk(done_o === 1'b1, "R11 done reached", done_o, 1);
        // expected outcome from the requirements
        lim_eff = (v[15:0] == 16'd0) ? 1 : int'(v[15:0]);
        found = 1'b0; c = 0;
        for (int k = 0; k < lim_eff && !found; k++) begin
            if (v[48] == 1'b0) begin
                if (val_at(k)[7] == v[23]) begin found = 1'b1; c = k; end   // R5
            end else begin
                if (k >= 1 && val_at(k)[6] == val_at(k-1)[6]) begin found = 1'b1; c = k; end // R6
            end
        end
        if (found) begin
            e_reads = c + 2;                                                 // R7
            e_res   = val_at(c + 1);
            e_pass  = v[48] ? 1'b1 : (e_res == v[23:16]);                    // R8 R9
        end else begin
            e_reads = lim_eff;                                               // R10
            e_res   = val_at(lim_eff - 1);
            e_pass  = 1'b0;
        end
        chk(pass_o === e_pass, "R5/R6/R8/R9/R10 pass", pass_o, e_pass);
        chk(result_o === e_res, "R7/R10 result", result_o, e_res);
        chk(rd_k == e_reads, "R7/R10 read count", rd_k, e_reads);
        chk(addr_err == 0, "R4 read address", addr_err, 0);
        chk(strobe_err == 0, "R3 strobe length", strobe_err, 0);
        old_res = result_o; old_pass = pass_o;
        @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b0, "R11 single pulse then idle", done_o, 0);
        chk(result_o === old_res && pass_o === old_pass, "R11 outcome held", result_o, old_res);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy_o === 1'b0 && done_o === 1'b0 && rd_en_o === 1'b0, "R1 idle after reset", busy_o, 0);
        chk(pass_o === 1'b0 && result_o === 8'h00, "R1 outcome cleared", result_o, 0);
        repeat (5) @(negedge clk);
        chk(rd_k == 0, "R1 no read without start", rd_k, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_op(VEC[i], 16'h1000 + 16'(i * 16'h0111), 1'b0);
        end

        // R2 start pulse while busy must not disturb the running operation
        run_op({1'b0, 8'd6, 8'h3C, 8'h70, 8'h3C, 16'd20}, 16'h1234, 1'b1);
        // same scenario in toggle mode
        run_op({1'b1, 8'd5, 8'h2D, 8'h40, 8'h2D, 16'd20}, 16'h4321, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule